// File: doc/BRIEF.md
# Multi-Port Interleaved Memory Arbiter

This block sits between four independent requester ports and a bank of up to four memory modules. Each port issues word requests on an 18-bit address bus with a read/write flag and 36-bit data. Typically one port serves a processor and the other three serve I/O channels. Every port holds its own per-module configuration: a 3-bit base value, a two-way interleave flag, and one port-wide four-way flag that overrides the per-module flags. The block decodes each request into one target module and a 15-bit module-local word address. The interleave modes move high address bits into the low end of the local address, so that every local address is reached exactly once.

There is a single timer for the whole bank. While any module runs a memory cycle, no other cycle can start on any module, and every other port waits. Pending ports are served by fixed priority, with port 0 highest. The grant is sampled only while the bank is idle. A cycle lasts `CYC_CLKS` clocks and ends with a one-clock acknowledge. Read data is valid in that same clock. Some requests match no usable module, or match more than one. These get a one-clock non-existent-memory pulse instead of an acknowledge, and no cycle is run. A port can be switched off for all modules, and a module can be switched off for all ports. A module can also be marked as not fitted.

The storage behind each module is a small synchronous RAM of `2**RAM_AW` words. The 15-bit local address is XOR-folded in `RAM_AW`-bit chunks to index it, so every local address bit affects which word is reached.

Top module: `ilv_mem_hub`

## Requirements
- R1: After reset, `ack`, `nxm` and `bank_busy` are all low.
- R2: Without interleave, module m answers port p when addr[17:15] equals the port's base for m. The local address is addr[14:0].
- R3: With the two-way flag set for (p,m), module m answers when addr[17:16] equals base[2:1] and addr[0] equals base[0]. The local address is {addr[14:1], addr[15]}.
- R4: With the port's four-way flag set, every module of that port ignores its two-way flag. Module m answers when addr[17] equals base[2] and addr[1:0] equals base[1:0]. The local address is {addr[14:2], addr[16:15]}.
- R5: At most one cycle runs in the whole bank. `bank_busy` stays high for exactly `CYC_CLKS` clocks per cycle. A request to any module stalls while it is high.
- R6: A cycle ends with `ack` high for one clock on the requesting port only. A read returns in `rdata` during that clock the word last written to the same module and local address.
- R7: Among pending ports, the lowest index is served first. A port that raises its request while a cycle runs is considered only once the bank is idle again.
- R8: When a port's off bit is set, every request from that port gets `nxm`.
- R9: A module whose off bit is set, or whose fitted bit is clear, answers no port.
- R10: A request that matches zero or two or more usable modules gets a one-clock `nxm` and starts no cycle.
- R11: When the bank is idle, `ack` appears `CYC_CLKS`+1 rising edges after the request is first seen, and `nxm` appears one edge after. The grant is sampled only when `ack`/`nxm` is not already being shown to that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_port_off | input | NP | Per-port off bit (blocks the port from all modules) |
| cfg_port_quad | input | NP | Per-port four-way interleave flag |
| cfg_mod_fitted | input | NM | Module present bits |
| cfg_mod_off | input | NM | Per-module off bit (hides the module from all ports) |
| cfg_pair | input | NP*NM | Two-way flag, bit p*NM+m |
| cfg_base | input | NP*NM*3 | Base value, field (p*NM+m)*3 +: 3 |
| req | input | NP | Request per port, held until ack or nxm |
| wr | input | NP | Write flag per port |
| addr | input | NP*18 | Word address per port, field p*18 +: 18 |
| wdata | input | NP*36 | Write data per port, field p*36 +: 36 |
| ack | output | NP | One-clock completion pulse |
| nxm | output | NP | One-clock non-existent-memory pulse |
| rdata | output | 36 | Read data, valid with ack |
| bank_busy | output | 1 | A memory cycle is in progress |

## Verification
The coinciding functions are the acknowledge that ends one port's cycle and the grant of another port's stalled request. Both must fall in the same clock. The bench provokes this by starting a cycle on port 2 and then raising requests on ports 0, 1 and 3 while the bank is busy. It judges the outcome by the order of the acknowledges (2, 0, 1, 3) and by a spacing of exactly `CYC_CLKS`+1 clocks between them, which leaves no idle clock and no overlap. Around that test, sweeps over every interleave mode and every disable combination compare the response type, latency, busy length and read-back data against arithmetic expectations.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;
   // Number of address bits above the local range needed by four-way mode
   localparam int unsigned ILV_MIN_BASE_W = 3;

   typedef enum logic [1:0] {
      RESP_NONE = 2'd0,
      RESP_ACK  = 2'd1,
      RESP_NXM  = 2'd2
   } ilv_resp_e;
endpackage

// File: rtl/ilv_port_decode.sv
`timescale 1ns/1ps
module ilv_port_decode #(
   parameter int unsigned NM  = 4,
   parameter int unsigned AW  = 18,
   parameter int unsigned LAW = 15
) (
   input  logic [AW-1:0]          addr,
   input  logic                   port_off,
   input  logic                   quad,
   input  logic [NM-1:0]          pair,
   input  logic [NM-1:0]          usable,
   input  logic [NM*(AW-LAW)-1:0] base,
   output logic [NM-1:0]          hit,
   output logic [NM*LAW-1:0]      loc
);
   localparam int unsigned BW = AW - LAW;

   if (BW < ilv_pkg::ILV_MIN_BASE_W) begin : g_bad_bw
      $error("ilv_port_decode: AW-LAW must be at least 3");
   end

   for (genvar m = 0; m < NM; m++) begin : g_mod
      logic [BW-1:0]  base_m;
      logic           match;
      logic [LAW-1:0] lcl;

      assign base_m = base[m*BW +: BW];

      always_comb begin
         if (quad) begin
            match = (addr[AW-1:LAW+2] == base_m[BW-1:2]) && (addr[1:0] == base_m[1:0]);
            lcl   = {addr[LAW-1:2], addr[LAW+1:LAW]};
         end else if (pair[m]) begin
            match = (addr[AW-1:LAW+1] == base_m[BW-1:1]) && (addr[0] == base_m[0]);
            lcl   = {addr[LAW-1:1], addr[LAW]};
         end else begin
            match = (addr[AW-1:LAW] == base_m);
            lcl   = addr[LAW-1:0];
         end
      end

      assign hit[m]             = match & usable[m] & ~port_off;
      assign loc[m*LAW +: LAW]  = lcl;
   end
endmodule

// File: rtl/ilv_prio_arb.sv
`timescale 1ns/1ps
module ilv_prio_arb #(
   parameter int unsigned N  = 4,
   parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  pend,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   if (N < 2) begin : g_bad_n
      $error("ilv_prio_arb: at least two requesters required");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) idx = IW'(i);
      end
   end

   assign any = |pend;
   assign gnt = any ? (N'(1) << idx) : '0;
endmodule

// File: rtl/ilv_cycle_timer.sv
`timescale 1ns/1ps
module ilv_cycle_timer #(
   parameter int unsigned CYC = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int unsigned CW = (CYC > 2) ? $clog2(CYC) : 1;

   if (CYC < 2) begin : g_bad_cyc
      $error("ilv_cycle_timer: cycle length must be at least 2 clocks");
   end

   logic [CW-1:0] cnt;

   assign done = busy && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= CW'(CYC - 1);
      end else if (done) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt  <= cnt - 1'b1;
      end
   end

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy);  // R5
   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);  // R5
endmodule

// File: rtl/ilv_sync_ram.sv
`timescale 1ns/1ps
module ilv_sync_ram #(
   parameter int unsigned DW     = 36,
   parameter int unsigned LAW    = 15,
   parameter int unsigned RAM_AW = 5
) (
   input  logic           clk,
   input  logic           en,
   input  logic           we,
   input  logic [LAW-1:0] a,
   input  logic [DW-1:0]  d,
   output logic [DW-1:0]  q
);
   localparam int unsigned DEPTH = 1 << RAM_AW;

   if (RAM_AW > 12 || RAM_AW > LAW) begin : g_bad_depth
      $error("ilv_sync_ram: RAM_AW out of range");
   end

   logic [DW-1:0]     mem [DEPTH];
   logic [RAM_AW-1:0] idx;

   always_comb begin
      idx = '0;
      for (int k = 0; k < LAW; k += RAM_AW) begin
         idx = idx ^ RAM_AW'(a >> k);
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[idx] <= d;
         q <= mem[idx];
      end
   end
endmodule

// File: rtl/ilv_mem_hub.sv
`timescale 1ns/1ps
module ilv_mem_hub #(
   parameter int unsigned NP       = 4,
   parameter int unsigned NM       = 4,
   parameter int unsigned AW       = 18,
   parameter int unsigned DW       = 36,
   parameter int unsigned LAW      = 15,
   parameter int unsigned RAM_AW   = 5,
   parameter int unsigned CYC_CLKS = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NP-1:0]            cfg_port_off,
   input  logic [NP-1:0]            cfg_port_quad,
   input  logic [NM-1:0]            cfg_mod_fitted,
   input  logic [NM-1:0]            cfg_mod_off,
   input  logic [NP*NM-1:0]         cfg_pair,
   input  logic [NP*NM*(AW-LAW)-1:0] cfg_base,
   input  logic [NP-1:0]            req,
   input  logic [NP-1:0]            wr,
   input  logic [NP*AW-1:0]         addr,
   input  logic [NP*DW-1:0]         wdata,
   output logic [NP-1:0]            ack,
   output logic [NP-1:0]            nxm,
   output logic [DW-1:0]            rdata,
   output logic                     bank_busy
);
   localparam int unsigned BW  = AW - LAW;
   localparam int unsigned PIW = (NP > 1) ? $clog2(NP) : 1;
   localparam int unsigned MIW = (NM > 1) ? $clog2(NM) : 1;

   if (NP < 2 || NP > 16) begin : g_bad_np
      $error("ilv_mem_hub: NP out of range");
   end
   if (NM < 1 || NM > 16) begin : g_bad_nm
      $error("ilv_mem_hub: NM out of range");
   end
   if (BW < ilv_pkg::ILV_MIN_BASE_W) begin : g_bad_aw
      $error("ilv_mem_hub: AW must exceed LAW by at least 3");
   end

   // ---------------- per-port decode ----------------
   logic [NM-1:0]     usable;
   logic [NM-1:0]     hit_v [NP];
   logic [NM*LAW-1:0] loc_v [NP];

   assign usable = cfg_mod_fitted & ~cfg_mod_off;

   for (genvar p = 0; p < NP; p++) begin : g_port
      ilv_port_decode #(.NM(NM), .AW(AW), .LAW(LAW)) i_dec (
         .addr     (addr[p*AW +: AW]),
         .port_off (cfg_port_off[p]),
         .quad     (cfg_port_quad[p]),
         .pair     (cfg_pair[p*NM +: NM]),
         .usable   (usable),
         .base     (cfg_base[p*NM*BW +: NM*BW]),
         .hit      (hit_v[p]),
         .loc      (loc_v[p])
      );
   end

   // ---------------- arbitration ----------------
   logic [NP-1:0]  pend, gnt;
   logic [PIW-1:0] gidx;
   logic           any;

   assign pend = req & ~(ack | nxm);

   ilv_prio_arb #(.N(NP), .IW(PIW)) i_arb (
      .pend (pend),
      .gnt  (gnt),
      .idx  (gidx),
      .any  (any)
   );

   logic [NM-1:0]     sel_hit;
   logic [NM*LAW-1:0] sel_loc;
   logic [MIW-1:0]    sel_mod;
   int unsigned       n_hit;
   logic              good, start, reject, done;

   assign sel_hit = hit_v[gidx];
   assign sel_loc = loc_v[gidx];

   always_comb begin
      n_hit   = 0;
      sel_mod = '0;
      for (int m = 0; m < NM; m++) begin
         if (sel_hit[m]) begin
            n_hit   = n_hit + 1;
            sel_mod = MIW'(m);
         end
      end
   end

   assign good   = (n_hit == 1);
   assign start  = !bank_busy && any && good;
   assign reject = !bank_busy && any && !good;

   // ---------------- bank-wide cycle timer ----------------
   ilv_cycle_timer #(.CYC(CYC_CLKS)) i_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (bank_busy),
      .done  (done)
   );

   logic [PIW-1:0] cur_port;
   logic [MIW-1:0] cur_mod;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_port <= '0;
         cur_mod  <= '0;
         ack      <= '0;
         nxm      <= '0;
      end else begin
         if (start) begin
            cur_port <= gidx;
            cur_mod  <= sel_mod;
         end
         ack <= done ? (NP'(1) << cur_port) : '0;
         nxm <= reject ? gnt : '0;
      end
   end

   // ---------------- module storage ----------------
   logic [DW-1:0] ram_q [NM];

   for (genvar m = 0; m < NM; m++) begin : g_mod
      ilv_sync_ram #(.DW(DW), .LAW(LAW), .RAM_AW(RAM_AW)) i_ram (
         .clk (clk),
         .en  (start && sel_hit[m]),
         .we  (wr[gidx]),
         .a   (sel_loc[m*LAW +: LAW]),
         .d   (wdata[gidx*DW +: DW]),
         .q   (ram_q[m])
      );
   end

   assign rdata = ram_q[cur_mod];

   // ---------------- assertions ----------------
   AST_RESP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ack, nxm}));  // R6
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack) |=> !(|ack));  // R6
   AST_NXM_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|nxm) |-> !bank_busy);  // R10
   AST_END_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_busy) |-> (|ack));  // R5
   AST_ACK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack) |-> $past(bank_busy));  // R11
   AST_GNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && ((gnt & ~pend) == '0));  // R7
endmodule

// File: tb/test_ilv_mem_hub.sv
`timescale 1ns/1ps
module test_ilv_mem_hub;
   localparam int NP = 4, NM = 4, AW = 18, DW = 36, LAW = 15, RAM_AW = 5, CYC = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NP-1:0]      cfg_port_off, cfg_port_quad;
   logic [NM-1:0]      cfg_mod_fitted, cfg_mod_off;
   logic [NP*NM-1:0]   cfg_pair;
   logic [NP*NM*3-1:0] cfg_base;
   logic [NP-1:0]      req, wr;
   logic [NP*AW-1:0]   addr;
   logic [NP*DW-1:0]   wdata;
   logic [NP-1:0]      ack, nxm;
   logic [DW-1:0]      rdata;
   logic               bank_busy;

   int checks = 0, failures = 0;
   logic [DW-1:0] shadow [NM][32];

   always #5 clk = ~clk;

   ilv_mem_hub #(.NP(NP), .NM(NM), .AW(AW), .DW(DW), .LAW(LAW), .RAM_AW(RAM_AW),
                 .CYC_CLKS(CYC)) i_ilv_mem_hub (
      .clk(clk), .rst_n(rst_n), .cfg_port_off(cfg_port_off), .cfg_port_quad(cfg_port_quad),
      .cfg_mod_fitted(cfg_mod_fitted), .cfg_mod_off(cfg_mod_off), .cfg_pair(cfg_pair),
      .cfg_base(cfg_base), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
      .ack(ack), .nxm(nxm), .rdata(rdata), .bank_busy(bank_busy));

   task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic set_base(int p, int m, int v);
      cfg_base[(p*NM+m)*3 +: 3] = 3'(v);
   endtask

   task automatic cfg_plain();
      cfg_port_off = '0; cfg_port_quad = '0; cfg_mod_fitted = '1; cfg_mod_off = '0;
      cfg_pair = '0;
      for (int p = 0; p < NP; p++)
         for (int m = 0; m < NM; m++) set_base(p, m, m);
   endtask

   // Expected decode computed arithmetically from R2/R3/R4/R8/R9/R10
   task automatic exp_dec(int p, int a, output bit ok, output int mod, output int lc);
      int n = 0;
      mod = 0; lc = 0;
      for (int m = 0; m < NM; m++) begin
         int b = int'(cfg_base[(p*NM+m)*3 +: 3]);
         bit mt;
         int l;
         if (cfg_port_quad[p]) begin
            mt = ((a >> 17) == (b >> 2)) && ((a % 4) == (b % 4));
            l  = ((a % 32768) / 4) * 4 + ((a >> 15) % 4);
         end else if (cfg_pair[p*NM+m]) begin
            mt = ((a >> 16) == (b >> 1)) && ((a % 2) == (b % 2));
            l  = ((a % 32768) / 2) * 2 + ((a >> 15) % 2);
         end else begin
            mt = ((a >> 15) == b);
            l  = a % 32768;
         end
         if (mt && cfg_mod_fitted[m] && !cfg_mod_off[m] && !cfg_port_off[p]) begin
            n++; mod = m; lc = l;
         end
      end
      ok = (n == 1);
   endtask

   function automatic int fold(int lc);
      return (lc % 32) ^ ((lc / 32) % 32) ^ ((lc / 1024) % 32);
   endfunction

   task automatic access(int p, bit w, int a, logic [DW-1:0] d,
                         output int kind, output int lat, output int busy_n,
                         output logic [DW-1:0] rd);
      @(negedge clk);
      wr[p] = w; addr[p*AW +: AW] = AW'(a); wdata[p*DW +: DW] = d; req[p] = 1'b1;
      kind = 0; lat = 0; busy_n = 0;
      while (kind == 0 && lat < 200) begin
         @(posedge clk); @(negedge clk);
         lat++;
         if (bank_busy) busy_n++;
         if (ack[p]) kind = 1;
         else if (nxm[p]) kind = 2;
      end
      rd = rdata;
      req[p] = 1'b0;
   endtask

   task automatic sweep(int tag, string rq_hit, string rq_miss);
      for (int w = 1; w >= 0; w--)
         for (int p = 0; p < NP; p++)
            for (int hi = 0; hi < 8; hi++)
               for (int mi = 0; mi < 2; mi++)
                  for (int lo = 0; lo < 4; lo++) begin
                     int a = hi * 32768 + (mi * 1237) * 4 + lo;
                     bit ok; int mod, lc, kind, lat, bn;
                     logic [DW-1:0] d, rd;
                     d = {4'(p), 2'(w), 12'(tag), 18'(a)};
                     exp_dec(p, a, ok, mod, lc);
                     access(p, w[0], a, d, kind, lat, bn, rd);
                     if (ok) begin
                        chk(kind == 1 && lat == CYC + 1 && bn == CYC, rq_hit,
                            "ack/latency/busy (R5 R11)", 64'(kind*10000 + lat*100 + bn),
                            64'(10000 + (CYC+1)*100 + CYC));
                        if (w == 1) shadow[mod][fold(lc)] = d;
                        else chk(rd === shadow[mod][fold(lc)], "R6", "read data",
                                 64'(rd), 64'(shadow[mod][fold(lc)]));
                     end else begin
                        chk(kind == 2 && lat == 1 && bn == 0, rq_miss,
                            "nxm/no cycle (R10 R11)", 64'(kind*10000 + lat*100 + bn),
                            64'(20000 + 100));
                     end
                  end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog R5 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      req = '0; wr = '0; addr = '0; wdata = '0; cfg_base = '0;
      cfg_plain();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ack == '0 && nxm == '0 && bank_busy == 1'b0, "R1", "reset outputs",
          64'({ack, nxm, bank_busy}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk(ack == '0 && nxm == '0 && bank_busy == 1'b0, "R1", "after reset release",
          64'({ack, nxm, bank_busy}), 64'(0));

      // R2: no interleave
      cfg_plain();
      sweep(1, "R2", "R10");

      // R3: two-way on every module
      cfg_plain(); cfg_pair = '1;
      sweep(2, "R3", "R10");

      // R4: four-way overrides the two-way flags
      cfg_plain(); cfg_pair = '1; cfg_port_quad = '1;
      sweep(3, "R4", "R10");

      // Mixed modes per port, upper-half bases on port 0
      cfg_plain();
      for (int m = 0; m < NM; m++) set_base(0, m, m + 4);
      cfg_pair[1*NM +: NM] = '1;
      cfg_port_quad[2] = 1'b1;
      sweep(4, "R4", "R10");

      // R8 / R9: port off, module off, module not fitted
      cfg_plain(); cfg_port_off[2] = 1'b1; cfg_mod_off[1] = 1'b1; cfg_mod_fitted[3] = 1'b0;
      sweep(5, "R2", "R9");
      begin
         int kind, lat, bn; logic [DW-1:0] rd;
         access(2, 1'b0, 0, '0, kind, lat, bn, rd);
         chk(kind == 2, "R8", "off port to live module", 64'(kind), 64'(2));
         access(0, 1'b0, 1 * 32768, '0, kind, lat, bn, rd);
         chk(kind == 2, "R9", "module switched off", 64'(kind), 64'(2));
      end

      // R10: two modules claim the same address
      begin
         int kind, lat, bn; logic [DW-1:0] rd;
         cfg_plain(); set_base(0, 1, 0);
         access(0, 1'b1, 5, 36'h1, kind, lat, bn, rd);
         chk(kind == 2 && lat == 1 && bn == 0, "R10", "double match",
             64'(kind*10000 + lat*100 + bn), 64'(20100));
         access(1, 1'b1, 5, 36'h1, kind, lat, bn, rd);
         chk(kind == 1, "R10", "other port unaffected", 64'(kind), 64'(1));
      end

      // R7 + R5: stalled requests, fixed priority, back-to-back grant on ack
      begin
         int order [4];
         int gaps [4];
         int n = 0, t = 0, last = 0;
         cfg_plain();
         @(negedge clk);
         for (int p = 0; p < NP; p++) begin
            addr[p*AW +: AW] = AW'(p * 32768 + 9);
            wdata[p*DW +: DW] = 36'(p + 100);
            wr[p] = 1'b1;
         end
         req = 4'b0100;
         @(posedge clk); @(negedge clk);
         t = 1;
         req = req | 4'b1011;
         while (n < 4 && t < 300) begin
            @(posedge clk); @(negedge clk);
            t++;
            for (int p = 0; p < NP; p++)
               if (ack[p]) begin
                  order[n] = p; gaps[n] = t - last; last = t; n++;
                  req[p] = 1'b0;
               end
         end
         chk(n == 4, "R7", "all stalled ports served", 64'(n), 64'(4));
         chk(order[0] == 2, "R7", "first served", 64'(order[0]), 64'(2));
         chk(order[1] == 0, "R7", "second served", 64'(order[1]), 64'(0));
         chk(order[2] == 1, "R7", "third served", 64'(order[2]), 64'(1));
         chk(order[3] == 3, "R7", "fourth served", 64'(order[3]), 64'(3));
         chk(gaps[0] == CYC + 1, "R11", "first ack latency", 64'(gaps[0]), 64'(CYC + 1));
         for (int i = 1; i < 4; i++)
            chk(gaps[i] == CYC + 1, "R5", "ack-to-ack spacing", 64'(gaps[i]), 64'(CYC + 1));
         wr = '0;
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule